// File: doc/BRIEF.md
# Fetch Exception Priority Merger

This block gathers every fault source that can affect one returned instruction fetch block and reduces them to a single exception code. That code travels alongside the instruction data. The sources are:

- an exception already decided by address translation;
- a memory-protection fault;
- ECC failures in the tag (meta) array and in the data array;
- a corruption flag carried back from the next-level cache.

A control-register parity enable decides whether local array ECC failures become a synchronous access fault. When that bit is off, the failures are still signalled on an error pulse but raise no exception.

Beside the code, the block produces three signals:

- a cancel, which stops any outstanding fetch or prefetch to the next level when the block is already doomed;
- a data-unusable flag, which keeps faulting instructions from being executed;
- the error pulse for an external error collector.

A tag ECC failure must fault even when the lookup reports a miss, because a corrupted tag can turn a real hit into a false miss. For that reason the merger takes no hit input, and a miss can never mask the fault. All outputs are registered: a fetch presented in one cycle shows its result in the next.

Top module: `fexc_merge`

## Requirements
- R1: After reset, and until the first fetch is sampled, exc_vld_o, exc_code_o, req_cancel_o, data_bad_o and err_pulse_o are all 0.
- R2: Exception codes are 0 = none, 1 = page fault, 2 = access fault, 3 = guest page fault. xlat_exc_i uses the same encoding. When xlat_exc_i is nonzero, exc_code_o equals it, whatever the other sources are.
- R3: With no translation exception, a protection fault yields code 2.
- R4: With no translation or protection fault and no next-level corruption, a meta or data ECC error yields code 2 when parity_en_i is 1, and code 0 when parity_en_i is 0.
- R5: With no translation exception, next-level corruption yields code 2 regardless of parity_en_i.
- R6: req_cancel_o is 1 exactly when the fetch had a translation exception, a protection fault, or a meta ECC error with parity_en_i set. Data ECC errors and next-level corruption alone do not cancel.
- R7: data_bad_o is 1 exactly when the reported code is nonzero.
- R8: err_pulse_o is 1 when any of the meta ECC, data ECC or next-level corruption flags was set, independent of parity_en_i.
- R9: Results appear one cycle after the fetch is sampled. A cycle with fetch_vld_i low gives all outputs 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld_i | input | 1 | A fetch block's fault flags are presented |
| xlat_exc_i | input | 2 | Translation exception code |
| pmp_fault_i | input | 1 | Memory-protection fault |
| meta_ecc_err_i | input | 1 | Tag array ECC failure |
| data_ecc_err_i | input | 1 | Data array ECC failure |
| l2_corrupt_i | input | 1 | Next-level cache returned corrupt data |
| parity_en_i | input | 1 | Control bit enabling ECC-to-exception conversion |
| exc_vld_o | output | 1 | Registered result valid |
| exc_code_o | output | 2 | Merged exception code |
| req_cancel_o | output | 1 | Cancel next-level fetch or prefetch for this block |
| data_bad_o | output | 1 | Instruction data must not be executed |
| err_pulse_o | output | 1 | Error report to external collector |

## Verification
The key overlap is a translation or protection fault arriving in the same cycle as an array ECC failure. The higher-priority code must win, while the error pulse still reports the ECC event. The bench provokes this by sweeping all 128 combinations of the seven fault and enable inputs. Each result is judged one cycle later against a priority function written independently in the bench. It also checks that a dropped fetch-valid clears the outputs in between.

// File: rtl/fexc_pkg.sv
package fexc_pkg;
  localparam int CODE_W = 2;
  typedef enum logic [CODE_W-1:0] {
    EXC_NONE = 2'd0,
    EXC_PF   = 2'd1,
    EXC_AF   = 2'd2,
    EXC_GPF  = 2'd3
  } exc_code_t;

  // Priority: translation > protection > ECC/corruption access fault
  function automatic exc_code_t pick_code(input exc_code_t xlat,
                                          input logic prot_af,
                                          input logic array_af);
    if (xlat != EXC_NONE) return xlat;
    if (prot_af)          return EXC_AF;
    if (array_af)         return EXC_AF;
    return EXC_NONE;
  endfunction
endpackage

// File: rtl/fexc_ecc_gate.sv
module fexc_ecc_gate (
  input  logic meta_ecc_err_i,
  input  logic data_ecc_err_i,
  input  logic l2_corrupt_i,
  input  logic parity_en_i,
  output logic array_af_o,
  output logic meta_cancel_o,
  output logic err_any_o
);
  logic local_err;
  assign local_err     = meta_ecc_err_i | data_ecc_err_i;
  assign array_af_o    = (parity_en_i & local_err) | l2_corrupt_i;
  assign meta_cancel_o = parity_en_i & meta_ecc_err_i;
  assign err_any_o     = local_err | l2_corrupt_i;
endmodule

// File: rtl/fexc_prio.sv
module fexc_prio
  import fexc_pkg::*;
(
  input  logic [CODE_W-1:0] xlat_exc_i,
  input  logic              pmp_fault_i,
  input  logic              array_af_i,
  input  logic              meta_cancel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              cancel_o
);
  assign code_o   = pick_code(exc_code_t'(xlat_exc_i), pmp_fault_i, array_af_i);
  assign cancel_o = (xlat_exc_i != EXC_NONE) | pmp_fault_i | meta_cancel_i;
endmodule

// File: rtl/fexc_merge.sv
module fexc_merge
  import fexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld_i,
  input  logic [CODE_W-1:0] xlat_exc_i,
  input  logic              pmp_fault_i,
  input  logic              meta_ecc_err_i,
  input  logic              data_ecc_err_i,
  input  logic              l2_corrupt_i,
  input  logic              parity_en_i,
  output logic              exc_vld_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic              req_cancel_o,
  output logic              data_bad_o,
  output logic              err_pulse_o
);
  // Named internal events for the checker
  logic              array_af_w;
  logic              meta_cancel_w;
  logic              err_any_w;
  logic [CODE_W-1:0] code_w;
  logic              cancel_w;

  fexc_ecc_gate u_gate (
    .meta_ecc_err_i (meta_ecc_err_i),
    .data_ecc_err_i (data_ecc_err_i),
    .l2_corrupt_i   (l2_corrupt_i),
    .parity_en_i    (parity_en_i),
    .array_af_o     (array_af_w),
    .meta_cancel_o  (meta_cancel_w),
    .err_any_o      (err_any_w)
  );

  fexc_prio u_prio (
    .xlat_exc_i    (xlat_exc_i),
    .pmp_fault_i   (pmp_fault_i),
    .array_af_i    (array_af_w),
    .meta_cancel_i (meta_cancel_w),
    .code_o        (code_w),
    .cancel_o      (cancel_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_vld_o    <= 1'b0;
      exc_code_o   <= EXC_NONE;
      req_cancel_o <= 1'b0;
      data_bad_o   <= 1'b0;
      err_pulse_o  <= 1'b0;
    end else begin
      exc_vld_o    <= fetch_vld_i;
      exc_code_o   <= fetch_vld_i ? code_w : EXC_NONE;
      req_cancel_o <= fetch_vld_i & cancel_w;
      data_bad_o   <= fetch_vld_i & (code_w != EXC_NONE);
      err_pulse_o  <= fetch_vld_i & err_any_w;
    end
  end
endmodule

// File: rtl/fexc_merge_chk.sv
module fexc_merge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_vld_i,
  input logic [1:0] xlat_exc_i,
  input logic       pmp_fault_i,
  input logic       meta_ecc_err_i,
  input logic       data_ecc_err_i,
  input logic       l2_corrupt_i,
  input logic       parity_en_i,
  input logic       exc_vld_o,
  input logic [1:0] exc_code_o,
  input logic       req_cancel_o,
  input logic       data_bad_o,
  input logic       err_pulse_o
);
  a_r2_xlat_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_i && xlat_exc_i != 2'd0) |=> (exc_code_o == $past(xlat_exc_i)));

  a_r4_parity_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_i && xlat_exc_i == 2'd0 && !pmp_fault_i && !l2_corrupt_i && !parity_en_i)
      |=> (exc_code_o == 2'd0));

  a_r6_meta_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_i && parity_en_i && meta_ecc_err_i) |=> req_cancel_o);

  a_r7_bad_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld_o |-> (data_bad_o == (exc_code_o != 2'd0)));

  a_r8_err_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_i && (meta_ecc_err_i || data_ecc_err_i || l2_corrupt_i)) |=> err_pulse_o);

  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld_i |=> (!exc_vld_o && exc_code_o == 2'd0 && !req_cancel_o && !err_pulse_o));
endmodule

bind fexc_merge fexc_merge_chk u_chk (.*);

// File: tb/fexc_merge_test.sv
module fexc_merge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld_i = 1'b0;
  logic [1:0] xlat_exc_i = 2'd0;
  logic pmp_fault_i = 1'b0, meta_ecc_err_i = 1'b0, data_ecc_err_i = 1'b0;
  logic l2_corrupt_i = 1'b0, parity_en_i = 1'b0;
  logic exc_vld_o, req_cancel_o, data_bad_o, err_pulse_o;
  logic [1:0] exc_code_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fexc_merge uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [6:0] p);
    @(negedge clk);
    fetch_vld_i    = v;
    xlat_exc_i     = p[1:0];
    pmp_fault_i    = p[2];
    meta_ecc_err_i = p[3];
    data_ecc_err_i = p[4];
    l2_corrupt_i   = p[5];
    parity_en_i    = p[6];
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vld", exc_vld_o, 0);
    check("R1 code", exc_code_o, 0);
    check("R1 cancel", req_cancel_o, 0);
    check("R1 bad", data_bad_o, 0);
    check("R1 err", err_pulse_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) begin
      int xl, pm, me, de, l2, pe, ecode, ecan, eerr;
      xl = i % 4; pm = (i >> 2) & 1; me = (i >> 3) & 1;
      de = (i >> 4) & 1; l2 = (i >> 5) & 1; pe = (i >> 6) & 1;
      if (xl != 0) ecode = xl;
      else if (pm == 1 || l2 == 1 || (pe == 1 && (me + de) > 0)) ecode = 2;
      else ecode = 0;
      ecan = (xl != 0 || pm == 1 || (pe == 1 && me == 1)) ? 1 : 0;
      eerr = (me + de + l2 > 0) ? 1 : 0;
      apply(1'b1, 7'(i));
      check("R9 vld", exc_vld_o, 1);
      if (xl != 0) check("R2 xlat priority", exc_code_o, ecode);
      else if (pm == 1) check("R3 protection af", exc_code_o, ecode);
      else if (l2 == 1) check("R5 l2 corrupt af", exc_code_o, ecode);
      else check("R4 ecc gated by parity", exc_code_o, ecode);
      check("R6 cancel", req_cancel_o, ecan);
      check("R7 data bad", data_bad_o, (ecode != 0) ? 1 : 0);
      check("R8 err pulse", err_pulse_o, eerr);
      // drop valid with faults still present
      apply(1'b0, 7'(i));
      check("R9 idle vld", exc_vld_o, 0);
      check("R9 idle code", exc_code_o, 0);
      check("R9 idle cancel", req_cancel_o, 0);
      check("R9 idle err", err_pulse_o, 0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule